// File: doc/BRIEF.md
# Power Management Event Register Block

This block is a small set of power-management registers reached through a byte-addressed I/O window. It holds an event status register, an event enable register, a control register and a free-running timer. It drives a level-sensitive system control interrupt (SCI) from the status bits that are enabled, ORed with one general-purpose event pair supplied from outside. A separate command port sets or clears the SCI-enable bit in the control register. The same port can also raise a one-cycle system management interrupt (SMI) pulse.

The window is 64 bytes long. It can be moved, and it is switched on by configuration bytes written through a simple byte port. Status bits are set by one-cycle event pulses and cleared by writing ones. The timer counts on a tick-enable input. It flags its own status bit when its top bit changes, but only while the timer interrupt is armed.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset the status, enable and control registers are zero, `sci` and `smi` are low, the window is disabled, and every read returns zero.
- R2: The window base is {config byte 0x41, config byte 0x40} ANDed with 0xFFC0. The window covers 64 bytes from that base. It decodes only while bit 0 of config byte 0x80 is set. Outside the window, reads return zero and writes have no effect.
- R3: Window offsets are 0x00 status, 0x02 enable, 0x04 control and 0x08 timer (read-only, zero-extended). Reads of any other offset return zero, and writes to any other offset change nothing.
- R4: Status bit 0 is the timer, bit 5 global lock, bit 8 power button and bit 10 real-time clock; all other status bits read 0. An event pulse sets its bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear arrive in the same cycle, the event wins.
- R5: On every clock, `sci` is updated to the OR of two terms. The first is (status AND enable) masked to bits 0, 5, 8 and 10. The second is (`gpe_sts` AND `gpe_en`). The result of this OR is visible one cycle later.
- R6: The timer advances by one on each cycle that `tmr_tick` is high and holds otherwise. When its top bit changes, timer status bit 0 is set, but only if enable bit 0 is set and status bit 0 is clear.
- R7: Command byte 0xF1 sets control bit 0, and 0xF0 clears it. Other command values leave it unchanged. A command takes priority over an I/O write to the control register in the same cycle.
- R8: Every command byte causes a one-cycle `smi` pulse in the next cycle, provided bit 1 of config byte 0x5B is set; otherwise it causes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | Combinational read data for io_addr |
| apm_wr | input | 1 | Command byte strobe |
| apm_cmd | input | 8 | Command byte |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | Real-time-clock event pulse |
| evt_glock | input | 1 | Global-lock event pulse |
| tmr_tick | input | 1 | Timer advance enable |
| gpe_sts | input | 1 | General-purpose event status bit |
| gpe_en | input | 1 | General-purpose event enable bit |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System management interrupt pulse |

## Verification
Register writes, event pulses, timer ticks and command bytes are applied just after a rising edge. They become visible on `io_rdata` from the following edge onward. `sci` and `smi` lag the state that drives them by exactly one more register, so each one reflects the state and inputs of the previous cycle. The bench's reference model follows the same cycle counting. It is compared on every falling edge against `sci`, `smi` and the read data at the address then on the bus.

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [15:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        apm_wr,
  input  logic [7:0]  apm_cmd,
  input  logic        evt_pwrbtn,
  input  logic        evt_rtc,
  input  logic        evt_glock,
  input  logic        tmr_tick,
  input  logic        gpe_sts,
  input  logic        gpe_en,
  output logic        sci,
  output logic        smi
);
  localparam int B_TMR = 0, B_GBL = 5, B_PWR = 8, B_RTC = 10;
  localparam logic [15:0] EVT_MASK = 16'h0521;
  localparam logic [5:0] O_STS = 6'h00, O_EN = 6'h02, O_CTL = 6'h04, O_TMR = 6'h08;
  localparam logic [7:0] CMD_ON = 8'hF1, CMD_OFF = 8'hF0;

  logic [15:0] sts, en, ctl;
  logic [TMR_W-1:0] tmr;
  logic [9:0]  base_hi;
  logic        win_en, smi_en;

  logic       hit;
  logic [5:0] off;
  logic       w_sts, w_en, w_ctl;
  logic [TMR_W-1:0] tmr_nx;
  logic       tmr_flip, armed;
  logic [15:0] set_v;

  assign off   = io_addr[5:0];
  assign hit   = win_en && (io_addr[15:6] == base_hi);
  assign w_sts = io_wr && hit && off == O_STS;
  assign w_en  = io_wr && hit && off == O_EN;
  assign w_ctl = io_wr && hit && off == O_CTL;

  assign tmr_nx   = tmr + TMR_W'(tmr_tick);
  assign tmr_flip = tmr_nx[TMR_W-1] != tmr[TMR_W-1];
  assign armed    = en[B_TMR] && !sts[B_TMR];

  always_comb begin
    set_v = '0;
    set_v[B_TMR] = tmr_flip && armed;
    set_v[B_GBL] = evt_glock;
    set_v[B_PWR] = evt_pwrbtn;
    set_v[B_RTC] = evt_rtc;
  end

  always_comb begin
    io_rdata = '0;
    if (hit) begin
      case (off)
        O_STS:   io_rdata = {16'h0, sts};
        O_EN:    io_rdata = {16'h0, en};
        O_CTL:   io_rdata = {16'h0, ctl};
        O_TMR:   io_rdata = 32'(tmr);
        default: io_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      win_en  <= 1'b0;
      smi_en  <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        8'h40: base_hi[1:0] <= cfg_wdata[7:6];
        8'h41: base_hi[9:2] <= cfg_wdata;
        8'h5B: smi_en       <= cfg_wdata[1];
        8'h80: win_en       <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
      ctl <= '0;
      tmr <= '0;
      sci <= 1'b0;
      smi <= 1'b0;
    end else begin
      sts <= ((w_sts ? (sts & ~io_wdata) : sts) | set_v) & EVT_MASK;
      if (w_en) en <= io_wdata;
      if (apm_wr && apm_cmd == CMD_ON)       ctl <= ctl | 16'h0001;
      else if (apm_wr && apm_cmd == CMD_OFF) ctl <= ctl & 16'hFFFE;
      else if (w_ctl)                        ctl <= io_wdata;
      tmr <= tmr_nx;
      sci <= (|(sts & en & EVT_MASK)) || (gpe_sts && gpe_en);
      smi <= apm_wr && smi_en;
    end
  end

  a_r2_win_off: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> io_rdata == 32'h0);
  a_r4_rtc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (w_sts && io_wdata[B_RTC] && !evt_rtc) |=> !sts[B_RTC]);
  a_r5_sci_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(sts & en & EVT_MASK)) && !(gpe_sts && gpe_en)) |=> !sci);
  a_r6_tmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(tmr));
  a_r7_cmd_on: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_cmd == CMD_ON) |=> ctl[0]);
  a_r8_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!apm_wr || !smi_en) |=> !smi);
endmodule

// File: tb/tb_pm_evt_regs.sv
module tb_pm_evt_regs;
  localparam int CLK_P = 10;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic io_wr = 0; logic [15:0] io_addr = 0, io_wdata = 0;
  logic [31:0] io_rdata;
  logic apm_wr = 0; logic [7:0] apm_cmd = 0;
  logic evt_pwrbtn = 0, evt_rtc = 0, evt_glock = 0, tmr_tick = 0, gpe_sts = 0, gpe_en = 0;
  logic sci, smi;

  pm_evt_regs #(.TMR_W(TW)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  int m_sts, m_en, m_ctl, m_tmr, m_base, m_win, m_smien;
  bit m_sci, m_smi;

  function automatic int model_read(int a);
    int o;
    if (!m_win || (a & 16'hFFC0) != m_base) return 0;
    o = a & 63;
    case (o)
      0: return m_sts;
      2: return m_en;
      4: return m_ctl;
      8: return m_tmr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ctl = 0; m_tmr = 0; m_base = 0; m_win = 0; m_smien = 0;
      m_sci = 0; m_smi = 0;
      chk_on = 1;
    end else begin
      int hit, o, nt, s_new;
      bit flip;
      m_sci = ((m_sts & m_en & 16'h0521) != 0) || (gpe_sts && gpe_en);
      m_smi = apm_wr && m_smien;
      hit = m_win && ((io_addr & 16'hFFC0) == m_base);
      o = io_addr & 63;
      nt = (m_tmr + (tmr_tick ? 1 : 0)) % (1 << TW);
      flip = ((nt >> (TW-1)) & 1) != ((m_tmr >> (TW-1)) & 1);
      s_new = m_sts;
      if (io_wr && hit && o == 0) s_new = s_new & ~io_wdata;
      if (flip && (m_en & 1) && !(m_sts & 1)) s_new |= 1;
      if (evt_glock) s_new |= 32;
      if (evt_pwrbtn) s_new |= 256;
      if (evt_rtc) s_new |= 1024;
      if (io_wr && hit && o == 2) m_en = io_wdata;
      if (apm_wr && apm_cmd == 8'hF1) m_ctl |= 1;
      else if (apm_wr && apm_cmd == 8'hF0) m_ctl &= 16'hFFFE;
      else if (io_wr && hit && o == 4) m_ctl = io_wdata;
      m_sts = s_new & 16'h0521;
      m_tmr = nt;
      if (cfg_wr) begin
        if (cfg_addr == 8'h40) m_base = (m_base & 16'hFF00) | (cfg_wdata & 8'hC0);
        if (cfg_addr == 8'h41) m_base = (m_base & 16'h00C0) | (cfg_wdata << 8);
        if (cfg_addr == 8'h5B) m_smien = (cfg_wdata >> 1) & 1;
        if (cfg_addr == 8'h80) m_win = cfg_wdata & 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on && rst_n) begin
    chk("R5 sci", sci, m_sci);
    chk("R8 smi", smi, m_smi);
    chk("R2/R3 rdata", io_rdata, model_read(io_addr));
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(); cfg_wr = 0; io_wr = 0; apm_wr = 0; evt_pwrbtn = 0; evt_rtc = 0; evt_glock = 0; endtask
  task automatic cfg(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; step(); idle();
  endtask
  task automatic iow(input logic [15:0] a, input logic [15:0] d);
    io_wr = 1; io_addr = a; io_wdata = d; step(); idle();
  endtask
  task automatic cmd(input logic [7:0] c);
    apm_wr = 1; apm_cmd = c; step(); idle();
  endtask
  task automatic rd(string tag, input logic [15:0] a, int exp);
    io_addr = a; #1; chk(tag, io_rdata, exp);
  endtask

  initial begin
    #(CLK_P*20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state observed on ports
    chk("R1 sci", sci, 0); chk("R1 smi", smi, 0);
    rst_n = 1; step();
    rd("R1 rd0", 16'h0000, 0);
    rd("R1 rd4", 16'h0004, 0);
    // R2 window disabled: write has no effect later
    iow(16'h0002, 16'hFFFF);
    cfg(8'h40, 8'hC5); cfg(8'h41, 8'h12);
    rd("R2 still off", 16'h12C2, 0);
    cfg(8'h80, 8'h01);
    rd("R2 en after disabled write", 16'h12C2, 0);
    // R3 enable and unmapped offsets
    iow(16'h12C2, 16'hA5A5);
    rd("R3 enable", 16'h12C2, 16'hA5A5);
    iow(16'h12C6, 16'h1234);
    rd("R3 off6 reads zero", 16'h12C6, 0);
    rd("R3 ctl untouched", 16'h12C4, 0);
    iow(16'h1302, 16'h0000);
    rd("R2 outside write ignored", 16'h12C2, 16'hA5A5);
    // R4 events and W1C
    iow(16'h12C2, 16'h0000);
    evt_rtc = 1; evt_pwrbtn = 1; evt_glock = 1; step(); idle();
    rd("R4 set", 16'h12C0, 16'h0520);
    iow(16'h12C0, 16'h0400);
    rd("R4 w1c", 16'h12C0, 16'h0120);
    io_wr = 1; io_addr = 16'h12C0; io_wdata = 16'h0100; evt_pwrbtn = 1; step(); idle();
    rd("R4 set wins", 16'h12C0, 16'h0120);
    // R5 SCI through enable and gpe
    iow(16'h12C2, 16'h0100);
    step(); chk("R5 sci on", sci, 1);
    iow(16'h12C0, 16'hFFFF); iow(16'h12C2, 16'h0000);
    gpe_sts = 1; gpe_en = 1; step(); step(); chk("R5 gpe", sci, 1);
    gpe_en = 0; step(); step(); chk("R5 gpe off", sci, 0);
    // R7/R8 commands
    cmd(8'hF1); rd("R7 on", 16'h12C4, 1);
    cmd(8'h33); rd("R7 other", 16'h12C4, 1);
    io_wr = 1; io_addr = 16'h12C4; io_wdata = 16'h0001; apm_wr = 1; apm_cmd = 8'hF0; step(); idle();
    rd("R7 cmd priority", 16'h12C4, 0);
    cfg(8'h5B, 8'h02);
    apm_wr = 1; apm_cmd = 8'h10; step(); idle();
    #(CLK_P/2 - 1); chk("R8 smi pulse", smi, 1); step(); chk("R8 smi ends", smi, 0);
    // R6 timer with arming
    iow(16'h12C2, 16'h0001);
    tmr_tick = 1; repeat (200) step(); tmr_tick = 0;
    rd("R6 tmr value", 16'h12C8, 200 + 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      io_wr = ($urandom % 6) == 0;
      io_addr = 16'h12C0 | ($urandom % 12);
      if (($urandom % 10) == 0) io_addr = $urandom;
      io_wdata = $urandom;
      apm_wr = ($urandom % 8) == 0;
      apm_cmd = ($urandom % 2) ? 8'hF1 : (($urandom % 2) ? 8'hF0 : 8'($urandom));
      evt_pwrbtn = ($urandom % 9) == 0; evt_rtc = ($urandom % 9) == 0; evt_glock = ($urandom % 9) == 0;
      tmr_tick = $urandom % 2; gpe_sts = $urandom % 2; gpe_en = $urandom % 2;
      cfg_wr = ($urandom % 50) == 0; cfg_addr = 8'h5B; cfg_wdata = $urandom;
      step();
    end
    idle(); step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule